// File: doc/BRIEF.md
# Power-Good and Overvoltage Supervisor

This block watches a digitized output-voltage reading from a multiphase regulator and decides two things: whether the rail may be reported good, and whether it has gone dangerously high. Every threshold is derived digitally from the target voltage code, with 12.5 mV per code step. The undervoltage limit is three quarters of the target. The overvoltage limit moves as the regulator powers up. When the supply is only partly up, a fixed limit applies to an auxiliary sense path. Once the supply is valid but the regulator is not yet enabled, a fixed limit applies to the differential sense path. During soft start the limit is the higher of that fixed level and the target plus a margin. After soft start, or after an overvoltage trip has disabled the regulator, only the target plus the margin applies.

The power-good flag rises only after soft start finishes. It drops while the rail sits under the undervoltage limit and comes back on its own when the rail recovers. It always drops when the regulator is disabled. An overvoltage event does not pull it down; instead a sticky trip latch raises a shutdown request. That latch clears on a full power loss or on a fresh enable.

All decisions are registered. An input change reaches the outputs on the second rising clock edge after it is applied.

Top module: `pgood_ov_supervisor`

## Requirements
- R1: While reset is asserted, and on the first edges after it is released, `powerGood`, `ovLatched` and `shutdownReq` are all 0.
- R2: `powerGood` is 1 only when `supplyValid`, `enableOk`, `codeValid` and `softStartDone` are all 1 and `diffSense` >= targetCode - (targetCode >> 2). Inputs reach the output two rising edges after they are applied.
- R3: While `diffSense` is below targetCode - (targetCode >> 2), `powerGood` is 0. Once the sense rises back to that level or above, `powerGood` returns to 1 with nothing else changed.
- R4: `powerGood` is 0 whenever any one of `supplyValid`, `enableOk` or `codeValid` is 0.
- R5: Setting the overvoltage latch has no effect on `powerGood`. A rail that is over the trip level but above the undervoltage limit keeps `powerGood` at 1.
- R6: With `supplyValid`=0 and `supplyPartial`=1, a trip happens exactly when `auxSense` > 144 (1.8 V). In this state `diffSense` is ignored.
- R7: With `supplyValid`=1, no trip latched, and the regulator not enabled (`enableOk`=0 or `codeValid`=0), a trip happens exactly when `diffSense` > 136 (1.7 V).
- R8: While enabled and `softStartDone`=0, a trip happens exactly when `diffSense` > max(136, targetCode + 16). 16 codes are 200 mV.
- R9: While enabled with `softStartDone`=1, a trip happens exactly when `diffSense` > targetCode + 16. While a trip is latched and `supplyValid`=1, the same limit applies whatever the enable state is.
- R10: A trip sets `ovLatched` and `shutdownReq` (they are always equal), and both stay set once the sense falls back. They clear only when `supplyValid` and `supplyPartial` are both 0, or on a 0-to-1 change of `enableOk`. A trip detected in the same cycle as the clear keeps them set.
- R11: With `supplyValid`=0 and `supplyPartial`=0, no trip occurs whatever the sense values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyPartial | input | 1 | Supply is partly up; only the auxiliary overvoltage check runs |
| supplyValid | input | 1 | Supply is fully valid |
| enableOk | input | 1 | All enable conditions are met |
| codeValid | input | 1 | Target code is a valid operating code |
| softStartDone | input | 1 | Soft-start ramp has completed |
| targetCode | input | CODE_W | Target voltage code, 12.5 mV per step |
| auxSense | input | CODE_W | Auxiliary-path sensed voltage code |
| diffSense | input | CODE_W | Differential-path sensed voltage code |
| powerGood | output | 1 | Rail is good |
| ovLatched | output | 1 | Sticky overvoltage trip |
| shutdownReq | output | 1 | Shutdown request driven by the trip |

## Verification
The bench sweeps every sense code across each power-up phase and several target codes. This includes targets whose 1.7 V limit and target-plus-margin limit sit one code apart, and targets near the top of the code range, where target + 16 no longer fits in CODE_W bits. A design that drops the carry would trip on low voltages near full scale. A design that picks the wrong limit for a phase, or uses >= where > is required, trips one code early or late on some point. The bench also drives the latch through each of its clear paths. Two of those checks catch a design where a supply dip to the partial state clears the latch, or where a re-enable clears the latch even though the trip is still present. The undervoltage sweep and the disable checks catch a power-good flag that latches low, follows the trip latch, or ignores one of the enable conditions.

// File: rtl/pgsup_pkg.sv
package pgsup_pkg;

  // Strobes from the control unit that select how the datapath compares.
  typedef struct packed {
    logic ovArmed;     // overvoltage comparison active at all
    logic useAux;      // compare the auxiliary path against the fixed aux limit
    logic usePreLimit; // fixed pre-enable limit participates
    logic useMargin;   // target-plus-margin limit participates
    logic uvArmed;     // undervoltage comparison active
  } supStrobes_t;

endpackage

// File: rtl/pgsup_datapath.sv
module pgsup_datapath
  import pgsup_pkg::*;
#(
  parameter int unsigned CODE_W         = 8,
  parameter int unsigned AUX_TRIP_CODE  = 144,
  parameter int unsigned PRE_TRIP_CODE  = 136,
  parameter int unsigned OV_MARGIN_CODE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  supStrobes_t       strobes,
  input  logic [CODE_W-1:0] targetCode,
  input  logic [CODE_W-1:0] auxSense,
  input  logic [CODE_W-1:0] diffSense,
  output logic              ovHit,
  output logic              uvHit
);

  localparam int unsigned EXT_W = CODE_W + 1;
  localparam logic [EXT_W-1:0] AUX_LIMIT = EXT_W'(AUX_TRIP_CODE);
  localparam logic [EXT_W-1:0] PRE_LIMIT = EXT_W'(PRE_TRIP_CODE);
  localparam logic [EXT_W-1:0] MARGIN    = EXT_W'(OV_MARGIN_CODE);

  logic [EXT_W-1:0]  marginLimit;
  logic [EXT_W-1:0]  ovLimit;
  logic [EXT_W-1:0]  senseExt;
  logic [CODE_W-1:0] uvLimit;

  // Target plus margin carries one extra bit so it cannot wrap near full scale.
  assign marginLimit = {1'b0, targetCode} + MARGIN;
  assign uvLimit     = targetCode - (targetCode >> 2);

  always_comb begin
    if (strobes.useAux) begin
      ovLimit  = AUX_LIMIT;
      senseExt = {1'b0, auxSense};
    end else begin
      senseExt = {1'b0, diffSense};
      if (strobes.usePreLimit && strobes.useMargin)
        ovLimit = (marginLimit > PRE_LIMIT) ? marginLimit : PRE_LIMIT;
      else if (strobes.usePreLimit)
        ovLimit = PRE_LIMIT;
      else
        ovLimit = marginLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovHit <= 1'b0;
      uvHit <= 1'b0;
    end else begin
      ovHit <= strobes.ovArmed && (senseExt > ovLimit);
      uvHit <= strobes.uvArmed && (diffSense < uvLimit);
    end
  end

  AST_AUX_LIMIT_RESPECTED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ovArmed && strobes.useAux && ({1'b0, auxSense} <= AUX_LIMIT)) |=> !ovHit); // R6

endmodule

// File: rtl/pgsup_control.sv
module pgsup_control
  import pgsup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyPartial,
  input  logic        supplyValid,
  input  logic        enableOk,
  input  logic        codeValid,
  input  logic        softStartDone,
  input  logic        ovHit,
  input  logic        uvHit,
  output supStrobes_t strobes,
  output logic        powerGood,
  output logic        ovLatched,
  output logic        shutdownReq
);

  logic enabledNow;
  logic poweredOff;
  logic enableRise;
  logic clearLatch;

  logic enablePrevQ;
  logic enabledQ;
  logic ssDoneQ;
  logic ovLatchQ;
  logic pgQ;

  assign enabledNow = supplyValid && enableOk && codeValid;
  assign poweredOff = !supplyValid && !supplyPartial;
  assign enableRise = enableOk && !enablePrevQ;
  assign clearLatch = poweredOff || enableRise;

  // Phase selection: which limits the datapath applies this cycle.
  always_comb begin
    strobes.ovArmed     = supplyValid || supplyPartial;
    strobes.useAux      = !supplyValid;
    strobes.uvArmed     = enabledNow;
    strobes.usePreLimit = 1'b0;
    strobes.useMargin   = 1'b0;
    if (supplyValid) begin
      if (ovLatchQ) begin
        strobes.useMargin = 1'b1;
      end else if (!enabledNow) begin
        strobes.usePreLimit = 1'b1;
      end else if (!softStartDone) begin
        strobes.usePreLimit = 1'b1;
        strobes.useMargin   = 1'b1;
      end else begin
        strobes.useMargin = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enablePrevQ <= 1'b0;
      enabledQ    <= 1'b0;
      ssDoneQ     <= 1'b0;
      ovLatchQ    <= 1'b0;
      pgQ         <= 1'b0;
    end else begin
      enablePrevQ <= enableOk;
      enabledQ    <= enabledNow;
      ssDoneQ     <= softStartDone;
      ovLatchQ    <= ovHit || (ovLatchQ && !clearLatch);
      pgQ         <= enabledQ && ssDoneQ && !uvHit;
    end
  end

  assign powerGood   = pgQ;
  assign ovLatched   = ovLatchQ;
  assign shutdownReq = ovLatchQ;

  AST_PG_BLOCKED_BY_UV: assert property (@(posedge clk) disable iff (!rstN)
    uvHit |=> !pgQ); // R3

  AST_PG_DROPS_ON_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    !supplyValid |-> ##2 !pgQ); // R4

  AST_TRIP_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovLatchQ && supplyValid && enableOk && $past(enableOk)) |=> ovLatchQ); // R10

  AST_NO_TRIP_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    poweredOff |=> !ovHit); // R11

endmodule

// File: rtl/pgood_ov_supervisor.sv
module pgood_ov_supervisor
  import pgsup_pkg::*;
#(
  parameter int unsigned CODE_W         = 8,
  parameter int unsigned AUX_TRIP_CODE  = 144,
  parameter int unsigned PRE_TRIP_CODE  = 136,
  parameter int unsigned OV_MARGIN_CODE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyPartial,
  input  logic              supplyValid,
  input  logic              enableOk,
  input  logic              codeValid,
  input  logic              softStartDone,
  input  logic [CODE_W-1:0] targetCode,
  input  logic [CODE_W-1:0] auxSense,
  input  logic [CODE_W-1:0] diffSense,
  output logic              powerGood,
  output logic              ovLatched,
  output logic              shutdownReq
);

  supStrobes_t strobes;
  logic        ovHit;
  logic        uvHit;

  pgsup_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .supplyPartial(supplyPartial),
    .supplyValid  (supplyValid),
    .enableOk     (enableOk),
    .codeValid    (codeValid),
    .softStartDone(softStartDone),
    .ovHit        (ovHit),
    .uvHit        (uvHit),
    .strobes      (strobes),
    .powerGood    (powerGood),
    .ovLatched    (ovLatched),
    .shutdownReq  (shutdownReq)
  );

  pgsup_datapath #(
    .CODE_W        (CODE_W),
    .AUX_TRIP_CODE (AUX_TRIP_CODE),
    .PRE_TRIP_CODE (PRE_TRIP_CODE),
    .OV_MARGIN_CODE(OV_MARGIN_CODE)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .targetCode(targetCode),
    .auxSense  (auxSense),
    .diffSense (diffSense),
    .ovHit     (ovHit),
    .uvHit     (uvHit)
  );

  AST_SHUTDOWN_FOLLOWS_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovLatched) |-> shutdownReq); // R10

endmodule

// File: tb/pgood_ov_supervisor_test.sv
module pgood_ov_supervisor_test;

  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 190000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         supplyPartial = 1'b0;
  logic         supplyValid = 1'b0;
  logic         enableOk = 1'b0;
  logic         codeValid = 1'b0;
  logic         softStartDone = 1'b0;
  logic [W-1:0] targetCode = '0;
  logic [W-1:0] auxSense = '0;
  logic [W-1:0] diffSense = '0;
  logic         powerGood;
  logic         ovLatched;
  logic         shutdownReq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  pgood_ov_supervisor uut (
    .clk(clk), .rstN(rstN), .supplyPartial(supplyPartial), .supplyValid(supplyValid),
    .enableOk(enableOk), .codeValid(codeValid), .softStartDone(softStartDone),
    .targetCode(targetCode), .auxSense(auxSense), .diffSense(diffSense),
    .powerGood(powerGood), .ovLatched(ovLatched), .shutdownReq(shutdownReq)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (target %0d aux %0d diff %0d)",
               req, actual, expected, targetCode, auxSense, diffSense);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic sv, input logic sp, input logic en, input logic cv,
                       input logic ssd, input int tgt, input int aux, input int dif);
    supplyValid = sv; supplyPartial = sp; enableOk = en; codeValid = cv;
    softStartDone = ssd; targetCode = W'(tgt); auxSense = W'(aux); diffSense = W'(dif);
  endtask

  task automatic powerDown();
    drive(0, 0, enableOk, codeValid, softStartDone, int'(targetCode), 0, 0);
    settle();
  endtask

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic sweepTarget(input int t);
    int uvLimit;
    uvLimit = t - (t >> 2);
    // R8: soft-start phase limit
    for (int v = 0; v < 256; v++) begin
      powerDown();
      drive(1, 1, 1, 1, 0, t, 0, v);
      settle();
      check("R8", ovLatched, (v > maxOf(136, t + 16)) ? 1'b1 : 1'b0);
    end
    // R9: running phase limit
    for (int v = 0; v < 256; v++) begin
      powerDown();
      drive(1, 1, 1, 1, 1, t, 0, v);
      settle();
      check("R9", ovLatched, (v > t + 16) ? 1'b1 : 1'b0);
    end
    // R2: power-good against the undervoltage limit, sense moving both ways
    powerDown();
    for (int v = 0; v < 256; v++) begin
      drive(1, 1, 1, 1, 1, t, 0, (v % 2 == 0) ? v : 255 - v);
      settle();
      check("R2", powerGood, (int'(diffSense) >= uvLimit) ? 1'b1 : 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    drive(1, 1, 1, 1, 1, 80, 200, 200);
    repeat (3) @(negedge clk);
    check("R1", powerGood, 1'b0);
    check("R1", ovLatched, 1'b0);
    check("R1", shutdownReq, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", powerGood, 1'b0);
    check("R1", ovLatched, 1'b0);

    // R11: unpowered, nothing trips
    drive(0, 0, 1, 1, 1, 40, 255, 255);
    settle();
    check("R11", ovLatched, 1'b0);
    check("R11", shutdownReq, 1'b0);

    // R6: partial supply, auxiliary limit, differential ignored
    for (int v = 0; v < 256; v++) begin
      powerDown();
      drive(0, 1, 1, 1, 1, 40, v, 0);
      settle();
      check("R6", ovLatched, (v > 144) ? 1'b1 : 1'b0);
    end
    powerDown();
    drive(0, 1, 1, 1, 1, 40, 0, 255);
    settle();
    check("R6 diff ignored", ovLatched, 1'b0);

    // R7: valid supply, not enabled (both ways of not being enabled)
    for (int v = 0; v < 256; v++) begin
      powerDown();
      drive(1, 1, 0, 1, 1, 200, 0, v);
      settle();
      check("R7", ovLatched, (v > 136) ? 1'b1 : 1'b0);
      powerDown();
      drive(1, 1, 1, 0, 1, 10, 0, v);
      settle();
      check("R7 code", ovLatched, (v > 136) ? 1'b1 : 1'b0);
    end

    // R8, R9, R2 across targets, including the 1.7 V crossover and overflow region
    for (int t = 0; t < 256; t += 17) sweepTarget(t);
    sweepTarget(120);
    sweepTarget(121);
    sweepTarget(250);

    // R3: recovery after undervoltage
    powerDown();
    drive(1, 1, 1, 1, 1, 80, 0, 80);
    settle();
    check("R3 good", powerGood, 1'b1);
    diffSense = 59;
    settle();
    check("R3 low", powerGood, 1'b0);
    diffSense = 60;
    settle();
    check("R3 recover", powerGood, 1'b1);

    // R4: each disable input drops power-good
    supplyValid = 0; settle();
    check("R4 supply", powerGood, 1'b0);
    supplyValid = 1; settle();
    check("R4 back", powerGood, 1'b1);
    codeValid = 0; settle();
    check("R4 code", powerGood, 1'b0);
    codeValid = 1; settle();
    enableOk = 0; settle();
    check("R4 enable", powerGood, 1'b0);
    softStartDone = 0; enableOk = 1; settle();
    check("R2 softstart", powerGood, 1'b0);
    softStartDone = 1; settle();

    // R5 and R10: trip while running, power-good unaffected, latch sticky
    diffSense = 120; settle();
    check("R5 pg", powerGood, 1'b1);
    check("R10 set", ovLatched, 1'b1);
    check("R10 req", shutdownReq, 1'b1);
    diffSense = 80; settle();
    check("R10 hold", ovLatched, 1'b1);
    check("R5 pg hold", powerGood, 1'b1);
    enableOk = 0; settle();
    check("R10 hold en low", shutdownReq, 1'b1);
    enableOk = 1; settle();
    check("R10 rise clears", ovLatched, 1'b0);
    check("R10 rise clears req", shutdownReq, 1'b0);

    // R10: partial dip keeps latch; full loss clears it
    diffSense = 120; settle();
    check("R10 retrip", ovLatched, 1'b1);
    diffSense = 0; supplyValid = 0; settle();
    check("R10 partial keeps", ovLatched, 1'b1);
    supplyPartial = 0; settle();
    check("R10 loss clears", ovLatched, 1'b0);

    // R9/R10: latched with enable low uses target+16; re-enable cannot clear a live trip
    drive(1, 1, 1, 1, 1, 80, 0, 120);
    settle();
    check("R10 trip", ovLatched, 1'b1);
    enableOk = 0; diffSense = 100; settle();
    enableOk = 1; settle();
    check("R9 latched limit", ovLatched, 1'b1);
    check("R10 set beats clear", shutdownReq, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule